// File: doc/BRIEF.md
# Interleaved Block-Code Correction Emulator

This block estimates the residual error rate a row-interleaved block corrector would leave behind. Its input is a stream of one-bit error flags, one per compared bit, as a bit-error-rate tester produces them. The block performs no decoding. It models such a decoder by counting erroneous symbols in each interleaved codeword and comparing the count with a correction limit T.

Flags are grouped into symbols of `cfg_sym_bits` bits. A symbol is bad if any of its flags is set. Consecutive symbols are dealt in turn to `cfg_depth` rows, and each row collects `cfg_cw_len` symbols. After the last flag of a table arrives, the block scans the rows. A row holding T or fewer bad symbols counts as repaired and is dropped. A row above T counts as a failed codeword, and its bit and symbol errors are added to saturating post-correction counters. Per-row counters live in two banks. One bank is scanned while the next table fills, so the stream never stalls at a table boundary.

A run begins with a `start` pulse while idle. The pulse latches the configuration and clears the counters. The run ends after `cfg_tables` tables have been evaluated. The input is valid/ready. A flag transfers on a rising edge where both `in_valid` and `in_ready` are high. `in_ready` is high only during a run, and only until the last flag of the final table has been taken. A source holding `in_valid` high while `in_ready` is low loses nothing: that flag is simply not taken yet.

Top module: `ibc_corr_emu`

## Requirements
- R1: A `start` pulse while `busy` is low latches symbol width, codeword length, T, depth and table count. A `start` pulse, or a change on the configuration pins, while `busy` is high has no effect on results.
- R2: `in_ready` is high exactly while `busy` is high and not every flag of the configured tables has been accepted. A flag presented with `in_ready` low is not counted.
- R3: Each group of `cfg_sym_bits` accepted flags forms one symbol, and the symbol is erroneous if any of those flags is 1. Symbol number s of a table (counting from 0) belongs to row s mod `cfg_depth`.
- R4: A table holds `cfg_depth` × `cfg_cw_len` symbols. After its last flag the block raises `done` for exactly one cycle. While `done` is high, `res_fail_rows` and `res_post_bits` hold that table's result.
- R5: A row with T or fewer erroneous symbols adds nothing to `res_fail_rows`, `res_post_bits` or any post-correction counter.
- R6: A row with more than T erroneous symbols adds 1 to `res_fail_rows` and `cnt_fail_cw`. It adds its raw bit-error count to `res_post_bits` and `cnt_post_bits`, and its erroneous-symbol count to `cnt_post_syms`.
- R7: With T = 0, any row containing an erroneous symbol is a failed codeword.
- R8: `cnt_bits` counts accepted flags and `cnt_raw` counts accepted flags equal to 1. These and the three post-correction counters are cleared by a run's `start` and stop at all-ones instead of wrapping.
- R9: At a table boundary inside a run, `in_ready` stays high, so tables can be streamed back to back without a stall.
- R10: After the result of the final configured table has been delivered, `busy` falls and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run; honoured only while idle |
| cfg_sym_bits | input | SWC_W | Bits per symbol, 2..MAX_SW |
| cfg_cw_len | input | NC_W | Symbols per codeword, 1..MAX_N |
| cfg_t | input | NC_W | Correction limit T in symbols |
| cfg_depth | input | DC_W | Interleave depth (rows), 1..MAX_D |
| cfg_tables | input | TBL_W | Number of tables in the run (0 starts nothing) |
| in_valid | input | 1 | Error flag present |
| in_ready | output | 1 | Block can take a flag |
| in_err | input | 1 | Error flag: 1 means the received bit differed |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle strobe with a table result |
| res_fail_rows | output | DC_W | Failed codewords in the table |
| res_post_bits | output | BT_W | Uncorrected bit errors in the table |
| cnt_bits | output | CNT_W | Accepted flags, saturating |
| cnt_raw | output | CNT_W | Raw bit errors, saturating |
| cnt_post_bits | output | CNT_W | Post-correction bit errors, saturating |
| cnt_post_syms | output | CNT_W | Post-correction symbol errors, saturating |
| cnt_fail_cw | output | CNT_W | Failed codewords, saturating |

## Verification
A wrong symbol position or row pointer sends errors to the wrong codeword. That shows as a wrong `res_fail_rows` or `res_post_bits` on the very next `done`, within one table. A row that is not cleared after its scan leaks into the next use of that bank. That shows two tables later, so patterns that pass one bank and then reuse it with clean data expose it. A broken saturation or clear in the cumulative counters shows only at run end. A stalled boundary shows at once as `in_ready` low between tables.

// File: rtl/ibc_pkg.sv
package ibc_pkg;
  typedef enum logic {EV_IDLE, EV_SCAN} ev_state_t;
endpackage

// File: rtl/ibc_dealer.sv
module ibc_dealer #(
  parameter int MAX_SW = 16,
  parameter int SWC_W  = 5,
  parameter int NC_W   = 8,
  parameter int DC_W   = 4,
  parameter int RI_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              acc,
  input  logic              err,
  input  logic [SWC_W-1:0]  cfg_sw,
  input  logic [NC_W-1:0]   cfg_n,
  input  logic [DC_W-1:0]   cfg_d,
  output logic              tbl_end,
  output logic              commit_v,
  output logic              commit_last,
  output logic              commit_bank,
  output logic [RI_W-1:0]   commit_row,
  output logic              commit_hit,
  output logic [SWC_W-1:0]  commit_nbits
);
  logic [SWC_W-1:0] bit_pos, sym_bits;
  logic             sym_hit, bank_q;
  logic [RI_W-1:0]  row_q;
  logic [NC_W-1:0]  col_q;
  logic sym_end, row_end, col_end;

  assign sym_end = acc && (bit_pos == cfg_sw - SWC_W'(1));
  assign row_end = (row_q == RI_W'(cfg_d - DC_W'(1)));
  assign col_end = (col_q == cfg_n - NC_W'(1));
  assign tbl_end = sym_end && row_end && col_end;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      bit_pos <= '0; sym_bits <= '0; sym_hit <= 1'b0;
      row_q <= '0; col_q <= '0; bank_q <= 1'b0;
      commit_v <= 1'b0; commit_last <= 1'b0; commit_bank <= 1'b0;
      commit_row <= '0; commit_hit <= 1'b0; commit_nbits <= '0;
    end else begin
      commit_v <= sym_end;
      if (acc) begin
        if (sym_end) begin
          commit_last  <= row_end && col_end;
          commit_bank  <= bank_q;
          commit_row   <= row_q;
          commit_hit   <= sym_hit | err;
          commit_nbits <= sym_bits + SWC_W'(err);
          bit_pos <= '0; sym_bits <= '0; sym_hit <= 1'b0;
          if (row_end) begin
            row_q <= '0;
            if (col_end) begin
              col_q  <= '0;
              bank_q <= ~bank_q;
            end else begin
              col_q <= col_q + NC_W'(1);
            end
          end else begin
            row_q <= row_q + RI_W'(1);
          end
        end else begin
          bit_pos  <= bit_pos + SWC_W'(1);
          sym_hit  <= sym_hit | err;
          sym_bits <= sym_bits + SWC_W'(err);
        end
      end
    end
  end

  // R3: symbols land only in configured rows, bit position stays inside a symbol
  assert_row_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    commit_v |-> (DC_W'(commit_row) < cfg_d));
  assert_bitpos_range_R3: assert property (@(posedge clk) disable iff (rst)
    (32'(bit_pos) < MAX_SW));
endmodule

// File: rtl/ibc_rowbank.sv
module ibc_rowbank #(
  parameter int MAX_D = 8,
  parameter int RI_W  = 3,
  parameter int NC_W  = 8,
  parameter int BR_W  = 12,
  parameter int SWC_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_v,
  input  logic              wr_bank,
  input  logic [RI_W-1:0]   wr_row,
  input  logic              wr_hit,
  input  logic [SWC_W-1:0]  wr_nbits,
  input  logic              clr_v,
  input  logic              rd_bank,
  input  logic [RI_W-1:0]   rd_row,
  output logic [NC_W-1:0]   rd_sc,
  output logic [BR_W-1:0]   rd_bc
);
  logic [NC_W-1:0] sc_q [2][MAX_D];
  logic [BR_W-1:0] bc_q [2][MAX_D];

  assign rd_sc = sc_q[rd_bank][rd_row];
  assign rd_bc = bc_q[rd_bank][rd_row];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < 2; b++) begin
        for (int r = 0; r < MAX_D; r++) begin
          sc_q[b][r] <= '0;
          bc_q[b][r] <= '0;
        end
      end
    end else begin
      if (wr_v) begin
        sc_q[wr_bank][wr_row] <= sc_q[wr_bank][wr_row] + NC_W'(wr_hit);
        bc_q[wr_bank][wr_row] <= bc_q[wr_bank][wr_row] + BR_W'(wr_nbits);
      end
      if (clr_v) begin
        sc_q[rd_bank][rd_row] <= '0;
        bc_q[rd_bank][rd_row] <= '0;
      end
    end
  end

  // R9: the filling bank and the bank under scan never coincide
  assert_bank_disjoint_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_v && clr_v) |-> (wr_bank != rd_bank));
endmodule

// File: rtl/ibc_eval.sv
module ibc_eval
  import ibc_pkg::*;
#(
  parameter int MAX_D = 8,
  parameter int RI_W  = 3,
  parameter int DC_W  = 4,
  parameter int NC_W  = 8,
  parameter int BR_W  = 12,
  parameter int BT_W  = 15,
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              start_v,
  input  logic              start_bank,
  input  logic [NC_W-1:0]   cfg_t,
  input  logic [DC_W-1:0]   cfg_d,
  input  logic [NC_W-1:0]   rd_sc,
  input  logic [BR_W-1:0]   rd_bc,
  output logic              rd_bank,
  output logic [RI_W-1:0]   rd_row,
  output logic              scan,
  output logic              done,
  output logic [DC_W-1:0]   res_fail_rows,
  output logic [BT_W-1:0]   res_post_bits,
  output logic [CNT_W-1:0]  cnt_post_bits,
  output logic [CNT_W-1:0]  cnt_post_syms,
  output logic [CNT_W-1:0]  cnt_fail_cw
);
  localparam int WIDE = CNT_W + BR_W + 1;

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                               input logic [BR_W-1:0] b);
    logic [WIDE-1:0] s;
    s = WIDE'(a) + WIDE'(b);
    if (s > WIDE'({CNT_W{1'b1}})) return {CNT_W{1'b1}};
    return s[CNT_W-1:0];
  endfunction

  ev_state_t       st;
  logic            bank_q;
  logic [RI_W-1:0] row_q;
  logic            fail, last;

  assign rd_bank = bank_q;
  assign rd_row  = row_q;
  assign scan    = (st == EV_SCAN);
  assign fail    = rd_sc > cfg_t;
  assign last    = (row_q == RI_W'(cfg_d - DC_W'(1)));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      st <= EV_IDLE; bank_q <= 1'b0; row_q <= '0; done <= 1'b0;
      res_fail_rows <= '0; res_post_bits <= '0;
      cnt_post_bits <= '0; cnt_post_syms <= '0; cnt_fail_cw <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        EV_IDLE: if (start_v) begin
          st <= EV_SCAN; bank_q <= start_bank; row_q <= '0;
          res_fail_rows <= '0; res_post_bits <= '0;
        end
        EV_SCAN: begin
          if (fail) begin
            res_fail_rows <= res_fail_rows + DC_W'(1);
            res_post_bits <= res_post_bits + BT_W'(rd_bc);
            cnt_post_bits <= sat_add(cnt_post_bits, rd_bc);
            cnt_post_syms <= sat_add(cnt_post_syms, BR_W'(rd_sc));
            cnt_fail_cw   <= sat_add(cnt_fail_cw, BR_W'(1));
          end
          if (last) begin
            st <= EV_IDLE; done <= 1'b1;
          end else begin
            row_q <= row_q + RI_W'(1);
          end
        end
      endcase
    end
  end

  assert_scan_row_R4: assert property (@(posedge clk) disable iff (rst)
    scan |-> (32'(rd_row) < MAX_D));
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_pass_row_silent_R5: assert property (@(posedge clk) disable iff (rst || clear)
    (scan && !fail) |=> (res_fail_rows == $past(res_fail_rows)));
  assert_fail_row_counted_R6: assert property (@(posedge clk) disable iff (rst || clear)
    (scan && fail) |=> (res_fail_rows == $past(res_fail_rows) + DC_W'(1)));
  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    !clear |=> (cnt_post_bits >= $past(cnt_post_bits)) && (cnt_fail_cw >= $past(cnt_fail_cw)));
endmodule

// File: rtl/ibc_corr_emu.sv
module ibc_corr_emu #(
  parameter int MAX_SW = 16,
  parameter int MAX_N  = 255,
  parameter int MAX_D  = 8,
  parameter int CNT_W  = 32,
  parameter int TBL_W  = 16,
  localparam int SWC_W = $clog2(MAX_SW + 1),
  localparam int NC_W  = $clog2(MAX_N + 1),
  localparam int DC_W  = $clog2(MAX_D + 1),
  localparam int RI_W  = (MAX_D > 1) ? $clog2(MAX_D) : 1,
  localparam int BR_W  = $clog2(MAX_N * MAX_SW + 1),
  localparam int BT_W  = $clog2(MAX_D * MAX_N * MAX_SW + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SWC_W-1:0]  cfg_sym_bits,
  input  logic [NC_W-1:0]   cfg_cw_len,
  input  logic [NC_W-1:0]   cfg_t,
  input  logic [DC_W-1:0]   cfg_depth,
  input  logic [TBL_W-1:0]  cfg_tables,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_err,
  output logic              busy,
  output logic              done,
  output logic [DC_W-1:0]   res_fail_rows,
  output logic [BT_W-1:0]   res_post_bits,
  output logic [CNT_W-1:0]  cnt_bits,
  output logic [CNT_W-1:0]  cnt_raw,
  output logic [CNT_W-1:0]  cnt_post_bits,
  output logic [CNT_W-1:0]  cnt_post_syms,
  output logic [CNT_W-1:0]  cnt_fail_cw
);
  logic [SWC_W-1:0] sw_q;
  logic [NC_W-1:0]  n_q, t_q;
  logic [DC_W-1:0]  d_q;
  logic [TBL_W-1:0] tables_q, fed_q, evd_q;
  logic clear, acc, tbl_end;
  logic c_v, c_last, c_bank, c_hit;
  logic [RI_W-1:0]  c_row, rd_row;
  logic [SWC_W-1:0] c_nbits;
  logic rd_bank, scan;
  logic [NC_W-1:0] rd_sc;
  logic [BR_W-1:0] rd_bc;

  assign clear    = start && !busy;
  assign in_ready = busy && (fed_q != tables_q);
  assign acc      = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; sw_q <= '0; n_q <= '0; t_q <= '0; d_q <= '0;
      tables_q <= '0; fed_q <= '0; evd_q <= '0; cnt_bits <= '0; cnt_raw <= '0;
    end else if (clear) begin
      sw_q <= cfg_sym_bits; n_q <= cfg_cw_len; t_q <= cfg_t; d_q <= cfg_depth;
      tables_q <= cfg_tables; fed_q <= '0; evd_q <= '0;
      cnt_bits <= '0; cnt_raw <= '0;
      busy <= (cfg_tables != '0);
    end else begin
      if (tbl_end) fed_q <= fed_q + TBL_W'(1);
      if (done) begin
        evd_q <= evd_q + TBL_W'(1);
        if (evd_q + TBL_W'(1) == tables_q) busy <= 1'b0;
      end
      if (acc) begin
        if (cnt_bits != {CNT_W{1'b1}}) cnt_bits <= cnt_bits + CNT_W'(1);
        if (in_err && cnt_raw != {CNT_W{1'b1}}) cnt_raw <= cnt_raw + CNT_W'(1);
      end
    end
  end

  ibc_dealer #(.MAX_SW(MAX_SW), .SWC_W(SWC_W), .NC_W(NC_W), .DC_W(DC_W), .RI_W(RI_W)) u_deal (
    .clk(clk), .rst(rst), .clear(clear), .acc(acc), .err(in_err),
    .cfg_sw(sw_q), .cfg_n(n_q), .cfg_d(d_q), .tbl_end(tbl_end),
    .commit_v(c_v), .commit_last(c_last), .commit_bank(c_bank),
    .commit_row(c_row), .commit_hit(c_hit), .commit_nbits(c_nbits));

  ibc_rowbank #(.MAX_D(MAX_D), .RI_W(RI_W), .NC_W(NC_W), .BR_W(BR_W), .SWC_W(SWC_W)) u_bank (
    .clk(clk), .rst(rst), .wr_v(c_v), .wr_bank(c_bank), .wr_row(c_row),
    .wr_hit(c_hit), .wr_nbits(c_nbits), .clr_v(scan), .rd_bank(rd_bank),
    .rd_row(rd_row), .rd_sc(rd_sc), .rd_bc(rd_bc));

  ibc_eval #(.MAX_D(MAX_D), .RI_W(RI_W), .DC_W(DC_W), .NC_W(NC_W), .BR_W(BR_W),
             .BT_W(BT_W), .CNT_W(CNT_W)) u_eval (
    .clk(clk), .rst(rst), .clear(clear), .start_v(c_v && c_last), .start_bank(c_bank),
    .cfg_t(t_q), .cfg_d(d_q), .rd_sc(rd_sc), .rd_bc(rd_bc), .rd_bank(rd_bank),
    .rd_row(rd_row), .scan(scan), .done(done), .res_fail_rows(res_fail_rows),
    .res_post_bits(res_post_bits), .cnt_post_bits(cnt_post_bits),
    .cnt_post_syms(cnt_post_syms), .cnt_fail_cw(cnt_fail_cw));

  // R1: latched configuration holds for the whole run
  assert_cfg_held_R1: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(sw_q) && $stable(t_q) && $stable(d_q) && $stable(n_q)));
  // R4: results never outnumber tables fed
  assert_results_follow_feed_R4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (evd_q <= fed_q));
endmodule

// File: tb/tb_ibc_corr_emu.sv
module tb_ibc_corr_emu;
  localparam int CNT_W = 8;
  localparam int CMAX  = 255;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, start, in_valid, in_err, in_ready, busy, done;
  logic [4:0]  cfg_sym_bits;
  logic [7:0]  cfg_cw_len, cfg_t;
  logic [3:0]  cfg_depth, res_fail_rows;
  logic [15:0] cfg_tables;
  logic [14:0] res_post_bits;
  logic [CNT_W-1:0] cnt_bits, cnt_raw, cnt_post_bits, cnt_post_syms, cnt_fail_cw;

  ibc_corr_emu #(.MAX_SW(16), .MAX_N(255), .MAX_D(8), .CNT_W(CNT_W), .TBL_W(16)) dut (
    .clk(clk), .rst(rst), .start(start), .cfg_sym_bits(cfg_sym_bits),
    .cfg_cw_len(cfg_cw_len), .cfg_t(cfg_t), .cfg_depth(cfg_depth), .cfg_tables(cfg_tables),
    .in_valid(in_valid), .in_ready(in_ready), .in_err(in_err), .busy(busy), .done(done),
    .res_fail_rows(res_fail_rows), .res_post_bits(res_post_bits), .cnt_bits(cnt_bits),
    .cnt_raw(cnt_raw), .cnt_post_bits(cnt_post_bits), .cnt_post_syms(cnt_post_syms),
    .cnt_fail_cw(cnt_fail_cw));

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  int pat [0:1023];
  int sw_c, n_c, d_c, t_c;
  int m_bits, m_raw, m_pb, m_ps, m_fc;
  int q_fail[$], q_bits[$];
  string q_tag[$];

  function automatic int sat(int a, int b);
    return (a + b > CMAX) ? CMAX : a + b;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic clear_pat();
    for (int i = 0; i < 1024; i++) pat[i] = 0;
  endtask

  task automatic start_run(int sw, int n, int d, int t, int tables);
    @(negedge clk);
    cfg_sym_bits = 5'(sw); cfg_cw_len = 8'(n); cfg_depth = 4'(d);
    cfg_t = 8'(t); cfg_tables = 16'(tables); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    sw_c = sw; n_c = n; d_c = d; t_c = t;
    m_bits = 0; m_raw = 0; m_pb = 0; m_ps = 0; m_fc = 0;
  endtask

  task automatic send_bit(bit e, int gap);
    repeat (gap) begin @(negedge clk); in_valid = 1'b0; end
    @(negedge clk);
    in_valid = 1'b1; in_err = e;
    while (!in_ready) @(negedge clk);
  endtask

  // Driver: computes the expected table result, queues it, then streams the flags.
  task automatic send_table(string tag, bit gaps);
    int rs [0:15];
    int rb [0:15];
    int fr = 0, pb = 0;
    for (int r = 0; r < 16; r++) begin rs[r] = 0; rb[r] = 0; end
    for (int s = 0; s < d_c * n_c; s++) begin
      if (pat[s] > 0) rs[s % d_c]++;
      rb[s % d_c] += pat[s];
      m_raw = sat(m_raw, pat[s]);
    end
    m_bits = sat(m_bits, sw_c * n_c * d_c);
    for (int r = 0; r < d_c; r++) begin
      if (rs[r] > t_c) begin
        fr++; pb += rb[r];
        m_pb = sat(m_pb, rb[r]); m_ps = sat(m_ps, rs[r]); m_fc = sat(m_fc, 1);
      end
    end
    q_fail.push_back(fr); q_bits.push_back(pb); q_tag.push_back(tag);
    for (int s = 0; s < d_c * n_c; s++)
      for (int b = 0; b < sw_c; b++)
        send_bit(b < pat[s], gaps ? int'($urandom_range(0, 2)) : 0);
  endtask

  // Monitor: pops the scoreboard on each result strobe.
  always @(negedge clk) begin
    if (!rst && done) begin
      if (q_fail.size() == 0) begin
        chk("R4 unexpected done", 1, 0);
      end else begin
        string tg;
        int ef, eb;
        tg = q_tag.pop_front(); ef = q_fail.pop_front(); eb = q_bits.pop_front();
        chk({tg, " fail rows"}, int'(res_fail_rows), ef);
        chk({tg, " post bits"}, int'(res_post_bits), eb);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_up();
  end

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_counters(string tag);
    chk({tag, " R8 cnt_bits"}, int'(cnt_bits), m_bits);
    chk({tag, " R8 cnt_raw"}, int'(cnt_raw), m_raw);
    chk({tag, " R8 cnt_post_bits"}, int'(cnt_post_bits), m_pb);
    chk({tag, " R8 cnt_post_syms"}, int'(cnt_post_syms), m_ps);
    chk({tag, " R8 cnt_fail_cw"}, int'(cnt_fail_cw), m_fc);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; in_valid = 1'b0; in_err = 1'b0;
    cfg_sym_bits = '0; cfg_cw_len = '0; cfg_t = '0; cfg_depth = '0; cfg_tables = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R10 busy after reset", int'(busy), 0);
    chk("R2 ready after reset", int'(in_ready), 0);
    chk("R8 cnt_bits after reset", int'(cnt_bits), 0);

    // Flags offered while idle must not be taken (R2)
    @(negedge clk); in_valid = 1'b1; in_err = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 ready while idle", int'(in_ready), 0);
    in_valid = 1'b0;

    // Run A: 4-bit symbols, 6-symbol codewords, depth 3, T=1, 7 tables
    start_run(4, 6, 3, 1, 7);
    clear_pat();                                  send_table("R3 clean", 1'b1);
    clear_pat(); pat[0] = 3;                      send_table("R5 single symbol", 1'b0);
    clear_pat(); for (int s = 0; s < 6; s++) pat[s] = 1;
    send_table("R6 burst over all rows", 1'b0);
    @(negedge clk);
    chk("R9 ready at boundary", int'(in_ready), 1);
    // Start pulse and new config while busy must be ignored (R1)
    in_valid = 1'b0; start = 1'b1;
    cfg_sym_bits = 5'd8; cfg_depth = 4'd1; cfg_t = 8'd0; cfg_cw_len = 8'd2; cfg_tables = 16'd1;
    @(negedge clk); start = 1'b0;
    clear_pat(); for (int s = 0; s < 3; s++) pat[s] = 2;
    send_table("R1 R3 burst spread by interleave", 1'b0);
    clear_pat(); pat[0] = 4; pat[3] = 1;          send_table("R6 row0 fails", 1'b1);
    clear_pat();
    for (int s = 0; s < 18; s++) begin
      int r;
      r = int'($urandom_range(0, 5));
      pat[s] = (r < 3) ? 0 : r - 2;
    end
    send_table("R6 random", 1'b1);
    clear_pat(); pat[11] = 1; pat[14] = 2; pat[17] = 1;
    send_table("R3 last row", 1'b0);
    @(negedge clk);
    chk("R2 ready after final table", int'(in_ready), 0);
    in_valid = 1'b0;
    wait_idle();
    chk("R4 all results delivered", q_fail.size(), 0);
    chk_counters("runA");
    chk("R8 cnt_bits saturated", int'(cnt_bits), CMAX);

    // Run B: 8-bit symbols, 4-symbol codewords, depth 1, T=0
    start_run(8, 4, 1, 0, 2);
    chk("R8 cleared by start", int'(cnt_fail_cw), 0);
    clear_pat(); pat[2] = 1;                      send_table("R7 one bad symbol", 1'b1);
    clear_pat(); pat[0] = 8;                      send_table("R7 full bad symbol", 1'b0);
    @(negedge clk); in_valid = 1'b0;
    wait_idle();
    chk("R10 busy after run", int'(busy), 0);
    chk("R10 results delivered", q_fail.size(), 0);
    chk_counters("runB");
    finish_up();
  end
endmodule